// File: doc/BRIEF.md
# Cascadable Serial-In Latched Display Driver Core

This block is the logic core of a serial-to-parallel output driver for a vacuum-fluorescent display. A bit stream enters on one pin and moves one stage per rising clock edge through a shift chain. By default the chain has 20 stages. A bank of level-sensitive holding latches copies the chain while the capture input is high, and keeps its contents while that input is low. Each latch bit drives one output enable.

A blanking input turns every output enable off without changing what the latches hold. The content of the final chain stage appears on a serial output pin, so several devices can be chained in series. The analog output stages are outside this block. Each output is a plain logic level: 1 means the source driver is on, 0 means the pull-down is on.

The serial interface has no valid/ready handshake and no back-pressure. Every rising clock edge shifts the chain, and a sender pauses the transfer by stopping the clock. The chain length is a parameter, so the same design covers shorter and longer variants. An asynchronous active-low reset clears both the chain and the latches so that simulation starts from a known state.

Top module: `vfd_serial_driver`

## Requirements
- R1: While `rst_n` is low, every chain stage and every latch is cleared, so `drive_on` is all zeros and `ser_out` is 0.
- R2: On each rising edge of `clk` with `rst_n` high, stage 0 takes `ser_in`, and every stage i (i > 0) takes the previous value of stage i-1. Bit i of `drive_on` belongs to stage i.
- R3: `ser_out` always equals the last stage, STAGES-1. A bit that enters on `ser_in` appears on `ser_out` after exactly STAGES rising edges.
- R4: While `latch_en` is high, each latch follows its chain stage continuously, including the changes caused by shifting.
- R5: While `latch_en` is low, the latches keep their contents, whatever the chain does.
- R6: While `blank` is high, every bit of `drive_on` is 0, whatever the latches hold.
- R7: `blank` has no effect on the latch contents. When `blank` falls, `drive_on` shows the values the latches captured, including any captured while `blank` was high.
- R8: While `blank` is low, each bit of `drive_on` equals its latch bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the chain advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of chain and latches |
| ser_in | input | 1 | Serial data into stage 0 |
| latch_en | input | 1 | High: latches transparent; low: latches hold |
| blank | input | 1 | High: all output enables forced off |
| drive_on | output | STAGES | Output enables, bit i for stage i (1 = source on) |
| ser_out | output | 1 | Last chain stage, for cascading |

## Verification
The checker assumes that `latch_en` and `blank` change only between rising clock edges. The bench meets this by driving every input on the falling edge. The checker also assumes that a capture pulse lasts at least one clock period. If it were shorter, a pulse falling between two edges would let the latches change in a way that no edge samples. The shift and serial-output properties are guarded so that they apply only once a full clock period has passed with reset released. The bench covers a load with the latches closed, a capture pulse, a complete STAGES-edge shift-out, a capture taken while blanked, and bypass operation with `latch_en` tied high and `blank` high throughout entry.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  // default chain length
  parameter int unsigned DEF_STAGES = 20;

  // meaning of a logic level on an output enable
  typedef enum logic {
    DRV_SINK   = 1'b0,
    DRV_SOURCE = 1'b1
  } drive_level_e;
endpackage

// File: rtl/vfd_shift_chain.sv
module vfd_shift_chain #(
  parameter int unsigned STAGES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic [STAGES-1:0] chain_q
);
  // one flop per stage; stage 0 is fed from the pin
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic feed;
    if (i == 0) begin : g_head
      assign feed = ser_in;
    end else begin : g_body
      assign feed = chain_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= feed;
    end
  end
endmodule

// File: rtl/vfd_latch_bank.sv
module vfd_latch_bank #(
  parameter int unsigned STAGES = 20
) (
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [STAGES-1:0] d,
  output logic [STAGES-1:0] q
);
  // level-sensitive storage: transparent while latch_en is high
  for (genvar i = 0; i < STAGES; i++) begin : g_bit
    always_latch begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (latch_en) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/vfd_output_gate.sv
module vfd_output_gate #(
  parameter int unsigned STAGES = 20
) (
  input  logic              blank,
  input  logic [STAGES-1:0] hold_q,
  output logic [STAGES-1:0] drive_on
);
  import vfd_pkg::*;
  for (genvar i = 0; i < STAGES; i++) begin : g_out
    drive_level_e lvl;
    always_comb begin
      if (blank) lvl = DRV_SINK;
      else       lvl = hold_q[i] ? DRV_SOURCE : DRV_SINK;
    end
    assign drive_on[i] = (lvl == DRV_SOURCE);
  end
endmodule

// File: rtl/vfd_serial_driver.sv
module vfd_serial_driver #(
  parameter int unsigned STAGES = vfd_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              latch_en,
  input  logic              blank,
  output logic [STAGES-1:0] drive_on,
  output logic              ser_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] hold_q;

  vfd_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .chain_q (chain_q)
  );

  vfd_latch_bank #(.STAGES(STAGES)) u_latch (
    .rst_n    (rst_n),
    .latch_en (latch_en),
    .d        (chain_q),
    .q        (hold_q)
  );

  vfd_output_gate #(.STAGES(STAGES)) u_gate (
    .blank    (blank),
    .hold_q   (hold_q),
    .drive_on (drive_on)
  );

  assign ser_out = chain_q[LAST];
endmodule

// File: rtl/vfd_serial_driver_chk.sv
module vfd_serial_driver_chk #(
  parameter int unsigned STAGES = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_in,
  input logic              latch_en,
  input logic              blank,
  input logic [STAGES-1:0] drive_on,
  input logic              ser_out,
  input logic [STAGES-1:0] chain_q,
  input logic [STAGES-1:0] hold_q
);
  // high once reset was released at the previous edge
  logic run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (drive_on == '0 && ser_out == 1'b0));

  assert_head_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> chain_q[0] == $past(ser_in));

  assert_shift_body_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> chain_q[STAGES-1:1] == $past(chain_q[STAGES-2:0]));

  assert_tail_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ser_out == $past(chain_q[STAGES-2]));

  assert_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> hold_q == chain_q);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !latch_en && $past(!latch_en)) |-> hold_q == $past(hold_q));

  assert_blank_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> drive_on == '0);

  assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> drive_on == hold_q);
endmodule

bind vfd_serial_driver vfd_serial_driver_chk #(.STAGES(STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_in   (ser_in),
  .latch_en (latch_en),
  .blank    (blank),
  .drive_on (drive_on),
  .ser_out  (ser_out),
  .chain_q  (chain_q),
  .hold_q   (hold_q)
);

// File: tb/sim_vfd_serial_driver.sv
`timescale 1ns/1ps
module sim_vfd_serial_driver;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_in = 1'b0;
  logic         latch_en = 1'b0;
  logic         blank = 1'b0;
  logic [W-1:0] drive_on;
  logic         ser_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference: index 0 is the entry stage
  bit mq[$];
  bit ml[W];

  always #2 clk = ~clk;

  vfd_serial_driver #(.STAGES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_en(latch_en),
    .blank(blank), .drive_on(drive_on), .ser_out(ser_out)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      mq.push_front(ser_in);
      void'(mq.pop_back());
    end
  end

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare the model with the design away from the edge, then drive the next inputs
  task automatic tick(input logic d, input logic s, input logic b);
    logic [W-1:0] exp;
    @(negedge clk);
    if (latch_en) for (int i = 0; i < W; i++) ml[i] = mq[i];
    for (int i = 0; i < W; i++) exp[i] = blank ? 1'b0 : ml[i];
    chk_vec("R8 model drive_on", drive_on, exp);
    chk_bit("R3 model ser_out", ser_out, mq[W-1]);
    ser_in = d; latch_en = s; blank = b;
    if (s) for (int i = 0; i < W; i++) ml[i] = mq[i];
    #1;
  endtask

  initial begin
    logic [W-1:0] pat, pat2;
    for (int i = 0; i < W; i++) begin mq.push_back(1'b0); ml[i] = 1'b0; end
    pat  = 20'hA5C3E;
    pat2 = 20'h3F09B;
    repeat (2) @(negedge clk);
    chk_vec("R1 reset drive_on", drive_on, '0);
    chk_bit("R1 reset ser_out", ser_out, 1'b0);
    rst_n = 1'b1;

    // load with latches closed: outputs must not move (R5)
    for (int k = 0; k < W; k++) tick(pat[W-1-k], 1'b0, 1'b0);
    chk_vec("R5 closed during load", drive_on, '0);

    // capture pulse (R4); then shift out exactly W edges (R2, R3)
    for (int j = 0; j <= W; j++) begin
      tick(1'b0, (j == 0), 1'b0);
      if (j == 0) chk_vec("R4 capture", drive_on, pat);
      chk_bit("R2 R3 shift-out", ser_out, (j < W) ? pat[W-1-j] : 1'b0);
    end
    chk_vec("R5 hold after shift-out", drive_on, {pat[W-2:0], 1'b0});

    // blanking asserted while capturing (R6, R7)
    for (int k = 0; k < W; k++) tick(pat2[W-1-k], 1'b0, 1'b1);
    tick(1'b0, 1'b1, 1'b1);
    chk_vec("R6 blank during capture", drive_on, '0);
    tick(1'b0, 1'b0, 1'b1);
    chk_vec("R6 blank held", drive_on, '0);
    tick(1'b0, 1'b0, 1'b0);
    chk_vec("R7 latches kept under blank", drive_on, {pat2[W-2:0], 1'b0});
    tick(1'b0, 1'b0, 1'b1);
    tick(1'b1, 1'b0, 1'b0);
    chk_vec("R7 blank toggle no effect", drive_on, {pat2[W-2:0], 1'b0});

    // bypass: latch_en held high, blank high during entry
    for (int k = 0; k < W; k++) begin
      tick(1'b1, 1'b1, 1'b1);
      chk_vec("R6 bypass entry hidden", drive_on, '0);
    end
    tick(1'b0, 1'b1, 1'b0);
    chk_vec("R4 R8 bypass follow", drive_on, '1);
    tick(1'b0, 1'b1, 1'b0);
    chk_vec("R4 transparent shift", drive_on, {{(W-1){1'b1}}, 1'b0});
    repeat (4) tick(1'b0, 1'b0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule